// File: doc/BRIEF.md
# PCI Base Address Register Bank

This block keeps the six base address registers of one PCI function and answers 32-bit configuration accesses aimed at them. Software sizes a region by writing all ones and reading back a size mask, then programs a base; the bank keeps the type bits that software may not change. It also holds a host-side address for each region: the programmed base added to a fixed window offset. IO-space regions use one window offset and memory-space regions use another. Whenever a programmed base changes that mapping, the bank emits a one-cycle notification.

Any register can be strapped at build time as a hardwired legacy IO location. Such a register is invisible to software: writes to it are dropped and reads return zero. Its host address is fixed at reset from its initial value. A static check on the size parameters raises an error output when a programmable region has a size that is not a power of two.

Top module: `pci_bar_bank`

## Requirements
- R1: Register n (0..5) answers at configuration offset 0x10+4n, and offset bits [1:0] are ignored. A read asserts `rd_valid` for one cycle on the next clock edge, with `rd_data` bits [7:0] holding byte 0 of the register. Reads of other offsets return zero, and writes to other offsets change nothing.
- R2: `cfg_error` is high exactly when a non-legacy register has a nonzero size that is not a power of two.
- R3: Writing 0xFFFFFFFF to a non-legacy register loads ~(size-1) above the type mask and keeps the old type bits. A register of size 0 therefore reads back only its type bits. The write changes neither the host address nor the change pulse.
- R4: Any other write keeps the old bits under the type mask and takes the written bits elsewhere. The type mask is 0x3 when bit 0 of the stored value is 1 (IO space) and 0xF otherwise (memory space).
- R5: A write of the kind in R4 whose masked value is nonzero sets the host address to the IO window plus that value (IO space) or to the memory window plus that value (memory space). The same clock edge makes `range_change` high for exactly one cycle.
- R6: A write of the kind in R4 whose masked value is zero updates the register but leaves the host address unchanged and raises no pulse.
- R7: A legacy register reads zero and ignores writes. Its host address equals the IO window plus its initial value from reset onward.
- R8: After reset, every non-legacy register holds its initial value and has host address zero, and `range_change` and `rd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Configuration access present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | 8 | Configuration byte offset |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid (one cycle after the read) |
| rd_data | output | 32 | Read data |
| host_addr | output | 6*AW | Host address per register, register n at bits [n*AW +: AW] |
| range_change | output | 1 | One-cycle pulse when a mapping changes |
| cfg_error | output | 1 | Illegal size parameter present |

## Verification
The hardest case to reach is the IO-space path after sizing. The type bit comes from the old stored value, so the bench first probes the IO register, which leaves bit 0 set under the size mask. It then writes a base with ones in the low bits and checks that the IO mask, and not the memory mask, was applied. The same check confirms that the IO window was used for the host address. A zero base written into a memory register, and writes to a legacy register, are each followed by read-back and a host-address check so that an improper change shows up at the ports. The size-error output needs an illegal parameter set, so the bench uses a second instance built with a size of 0x300.

// File: rtl/pci_bar_bank.sv
module pci_bar_bank #(
  parameter int NUM_BAR = 6,
  parameter int AW = 64,
  parameter logic [NUM_BAR*32-1:0] BAR_SIZE = {32'h0, 32'h0, 32'h1000, 32'h8, 32'h20, 32'h100},
  parameter logic [NUM_BAR*32-1:0] BAR_INIT = {32'h3F6, 32'h0, 32'h8, 32'h1F0, 32'h1, 32'h0},
  parameter logic [NUM_BAR-1:0] BAR_LEGACY = 6'b100100,
  parameter logic [AW-1:0] IO_WIN = 64'h0000_0801_FC00_0000,
  parameter logic [AW-1:0] MEM_WIN = 64'h0000_0800_0000_0000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [7:0]            req_offset,
  input  logic [31:0]           req_wdata,
  output logic                  rd_valid,
  output logic [31:0]           rd_data,
  output logic [NUM_BAR*AW-1:0] host_addr,
  output logic                  range_change,
  output logic                  cfg_error
);
  localparam int IW = (NUM_BAR > 1) ? $clog2(NUM_BAR) : 1;
  localparam logic [5:0] FIRST_SLOT = 6'd4;

  logic [31:0]   bar_q  [NUM_BAR];
  logic [AW-1:0] host_q [NUM_BAR];
  logic [NUM_BAR-1:0] size_bad;

  logic [5:0]  slot;
  logic        hit;
  logic [IW-1:0] sel;
  logic [31:0] old_v, tmask, size_v, nv, next_v;
  logic        is_io, probe, legacy_sel;

  assign slot = req_offset[7:2];
  assign hit  = (slot >= FIRST_SLOT) && (slot < FIRST_SLOT + 6'(NUM_BAR));
  assign sel  = IW'(slot - FIRST_SLOT);

  always_comb begin
    old_v      = bar_q[sel];
    size_v     = BAR_SIZE[32*sel +: 32];
    legacy_sel = BAR_LEGACY[sel];
    is_io      = old_v[0];
    tmask      = is_io ? 32'h3 : 32'hF;
    probe      = (req_wdata == 32'hFFFF_FFFF);
    nv         = (probe ? ~(size_v - 32'd1) : req_wdata) & ~tmask;
    next_v     = nv | (old_v & tmask);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_BAR; i++) begin
        bar_q[i]  <= BAR_LEGACY[i] ? 32'h0 : BAR_INIT[32*i +: 32];
        host_q[i] <= BAR_LEGACY[i] ? IO_WIN + AW'(BAR_INIT[32*i +: 32]) : '0;
      end
      rd_valid     <= 1'b0;
      rd_data      <= 32'h0;
      range_change <= 1'b0;
    end else begin
      rd_valid     <= req_valid && !req_write;
      range_change <= 1'b0;
      if (req_valid && !req_write)
        rd_data <= (hit && !legacy_sel) ? old_v : 32'h0;
      if (req_valid && req_write && hit && !legacy_sel) begin
        bar_q[sel] <= next_v;
        if (!probe && nv != 32'h0) begin
          host_q[sel]  <= (is_io ? IO_WIN : MEM_WIN) + AW'(nv);
          range_change <= 1'b1;
        end
      end
    end
  end

  for (genvar i = 0; i < NUM_BAR; i++) begin : g_bar
    assign host_addr[i*AW +: AW] = host_q[i];
    assign size_bad[i] = !BAR_LEGACY[i] && (BAR_SIZE[32*i +: 32] != 32'h0) &&
                         ((BAR_SIZE[32*i +: 32] & (BAR_SIZE[32*i +: 32] - 32'd1)) != 32'h0);
  end

  assign cfg_error = |size_bad;
endmodule

// File: rtl/pci_bar_bank_chk.sv
module pci_bar_bank_chk #(
  parameter int NUM_BAR = 6,
  parameter int AW = 64,
  parameter logic [NUM_BAR*32-1:0] BAR_INIT = '0,
  parameter logic [NUM_BAR-1:0] BAR_LEGACY = '0,
  parameter logic [AW-1:0] IO_WIN = '0
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_valid,
  input logic                  req_write,
  input logic [7:0]            req_offset,
  input logic                  rd_valid,
  input logic [31:0]           rd_data,
  input logic [NUM_BAR*AW-1:0] host_addr,
  input logic                  range_change
);
  logic leg_rd;
  always_comb begin
    leg_rd = 1'b0;
    for (int i = 0; i < NUM_BAR; i++)
      if (BAR_LEGACY[i] && req_offset[7:2] == 6'(4 + i)) leg_rd = req_valid && !req_write;
  end

  assert_rd_timing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid == $past(req_valid && !req_write));

  assert_pulse_after_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    range_change |-> $past(req_valid && req_write));

  assert_host_moves_with_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(host_addr) |-> range_change);

  assert_legacy_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(leg_rd) |-> rd_data == 32'h0);

  for (genvar i = 0; i < NUM_BAR; i++) begin : g_leg
    if (BAR_LEGACY[i]) begin : g_on
      assert_legacy_host_R7: assert property (@(posedge clk) disable iff (!rst_n)
        host_addr[i*AW +: AW] == IO_WIN + AW'(BAR_INIT[32*i +: 32]));
    end
  end
endmodule

bind pci_bar_bank pci_bar_bank_chk #(
  .NUM_BAR(NUM_BAR), .AW(AW), .BAR_INIT(BAR_INIT), .BAR_LEGACY(BAR_LEGACY), .IO_WIN(IO_WIN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_offset(req_offset), .rd_valid(rd_valid), .rd_data(rd_data),
  .host_addr(host_addr), .range_change(range_change)
);

// File: tb/tb_pci_bar_bank.sv
module tb_pci_bar_bank;
  localparam logic [63:0] IO_W  = 64'h0000_0801_FC00_0000;
  localparam logic [63:0] MEM_W = 64'h0000_0800_0000_0000;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [7:0] req_offset = 0;
  logic [31:0] req_wdata = 0;
  logic rd_valid, range_change, cfg_error;
  logic [31:0] rd_data;
  logic [6*64-1:0] host_addr;
  logic b_rv, b_rc, b_err;
  logic [31:0] b_rd;
  logic [6*64-1:0] b_host;

  int errors = 0, checks = 0;
  logic [31:0] q_exp[$];
  string q_tag[$];
  bit done = 0;

  always #10 clk = ~clk;

  pci_bar_bank dut (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_offset(req_offset), .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .host_addr(host_addr), .range_change(range_change), .cfg_error(cfg_error));

  pci_bar_bank #(.BAR_SIZE({32'h0, 32'h0, 32'h1000, 32'h8, 32'h20, 32'h300})) dut_bad (
    .clk(clk), .rst_n(rst_n), .req_valid(1'b0), .req_write(1'b0), .req_offset(8'h0),
    .req_wdata(32'h0), .rd_valid(b_rv), .rd_data(b_rd), .host_addr(b_host),
    .range_change(b_rc), .cfg_error(b_err));

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (q_exp.size() == 0) check("R1 unexpected rd_valid", 1, 0);
      else check(q_tag.pop_front(), rd_data, q_exp.pop_front());
    end
  end

  task automatic wr(logic [7:0] off, logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_offset = off; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(logic [7:0] off, logic [31:0] exp, string tag);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_offset = off;
    q_exp.push_back(exp); q_tag.push_back(tag);
    @(negedge clk);
    req_valid = 0;
  endtask

  function automatic logic [63:0] h(int n);
    return host_addr[n*64 +: 64];
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check("R8 rd_valid low in reset", rd_valid, 0);
    rst_n = 1;
    @(negedge clk);
    check("R8 range_change low", range_change, 0);
    check("R8 host0 zero", h(0), 0);
    check("R8 host3 zero", h(3), 0);
    check("R7 legacy host2", h(2), IO_W + 64'h1F0);
    check("R7 legacy host5", h(5), IO_W + 64'h3F6);
    check("R2 legal sizes", cfg_error, 0);
    check("R2 size 0x300 flagged", b_err, 1);
    rd(8'h10, 32'h0, "R8 bar0 init");
    rd(8'h14, 32'h1, "R8 bar1 init");
    rd(8'h18, 32'h0, "R7 legacy bar2 reads zero");
    rd(8'h1C, 32'h8, "R8 bar3 init");
    rd(8'h24, 32'h0, "R7 legacy bar5 reads zero");
    rd(8'h08, 32'h0, "R1 non-bar offset reads zero");

    wr(8'h10, 32'hFFFF_FFFF);
    check("R3 probe no pulse", range_change, 0);
    check("R3 probe host unchanged", h(0), 0);
    rd(8'h10, 32'hFFFF_FF00, "R3 bar0 size mask");
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h14, 32'hFFFF_FFE1, "R3 bar1 IO size mask keeps type");
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, 32'h0, "R3 size zero reads type bits only");

    wr(8'h10, 32'h8000_1234);
    check("R5 pulse bar0", range_change, 1);
    check("R5 host0 memory window", h(0), MEM_W + 64'h8000_1230);
    @(negedge clk);
    check("R5 pulse one cycle", range_change, 0);
    rd(8'h10, 32'h8000_1230, "R4 memory mask");

    wr(8'h14, 32'h0000_C0FF);
    check("R5 pulse bar1", range_change, 1);
    check("R5 host1 IO window", h(1), IO_W + 64'h0000_C0FC);
    rd(8'h14, 32'h0000_C0FD, "R4 IO mask");

    wr(8'h1C, 32'h0);
    check("R6 zero base no pulse", range_change, 0);
    check("R6 host3 unchanged", h(3), 0);
    rd(8'h1C, 32'h8, "R6 zero base keeps type");
    wr(8'h1C, 32'h1234_5677);
    check("R5 host3", h(3), MEM_W + 64'h1234_5670);
    rd(8'h1F, 32'h1234_5678, "R1 low offset bits ignored / R4");

    wr(8'h18, 32'h0000_5555);
    check("R7 legacy write no pulse", range_change, 0);
    check("R7 legacy host unchanged", h(2), IO_W + 64'h1F0);
    rd(8'h18, 32'h0, "R7 legacy write ignored");

    wr(8'h08, 32'hFFFF_FFFF);
    check("R1 non-bar write no pulse", range_change, 0);
    rd(8'h10, 32'h8000_1230, "R1 non-bar write leaves bar0");
    rd(8'h14, 32'h0000_C0FD, "R1 non-bar write leaves bar1");

    repeat (3) @(negedge clk);
    check("R1 all reads answered", q_exp.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule